// File: doc/BRIEF.md
# Master Clock Selector and Prescaler

This block builds the system master clock from one of four free-running source clocks: a slow clock, a main clock and the outputs of two PLLs. A glitch-free source multiplexer picks one of them, and a prescaler divides the result by a power of two from 1 to 64 or by 3. The whole path exists twice. One copy drives the main-domain master clock and the other drives the coprocessor master clock. The two copies share the source clocks and the write port, and have nothing else in common.

Software writes a source code and a prescaler code into one domain. The write clears that domain's ready flag on the next register-clock edge. A small sequencer in the register-clock domain then moves the multiplexer to the new source. The old source is stopped during its low phase before the new one is started during its own low phase. After that, the sequencer asks the prescaler to adopt the new ratio at a period boundary. Ready returns to 1 once the prescaler reports one complete output period at the new ratio. The interrupt line of each domain is ready gated by that domain's mask input, so software learns when a switch, for example to a slower clock, has actually finished.

Top module: `mck_sel_presc`

## Requirements
- R1: After reset both domains select source 0 (slow clock) with prescaler code 0 (divide by 1). The readback fields read source 0 and code 0, both ready flags are 1, and the master clock of each domain runs at the slow-clock period.
- R2: Source code 0, 1, 2 and 3 selects the slow clock, the main clock, PLL A and PLL B respectively (bit i of `src_clk`). With prescaler code 0 the master clock has the period of the selected source.
- R3: A write to a domain drives that domain's ready flag to 0 at the first `clk` rising edge that samples `wr_en`.
- R4: Ready returns to 1 only after the multiplexer handover to the written source is complete and the prescaler has produced one full output period at the new ratio. From that moment the master clock already runs at the new period.
- R5: Prescaler codes 0 to 6 divide the selected clock by 2 to the power of the code (1, 2, 4, 8, 16, 32, 64).
- R6: Prescaler code 7 divides by 3, with a high phase of one source cycle and a low phase of two.
- R7: For codes 1 to 6 the output high phase is exactly half the output period.
- R8: A source change produces no high or low phase on a master clock shorter than half the period of the fastest source involved, and no two sources of one domain are ever enabled at the same time.
- R9: `irq[d]` is 1 exactly when ready of domain d is 1 and `irq_mask[d]` is 1. It falls when a write clears ready or when the mask is cleared.
- R10: A write to one domain leaves the other domain's ready flag and master clock unchanged.
- R11: After a write, the readback fields of the written domain hold the written source code (bits [2d+1:2d] of `cfg_sel`) and prescaler code (bits [3d+2:3d] of `cfg_pres`). A second write made before ready returns decides the final clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register-interface clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_clk | input | 4 | Source clocks: bit 0 slow, 1 main, 2 PLL A, 3 PLL B |
| wr_en | input | 1 | Write strobe for one domain's clock fields |
| wr_dom | input | 1 | Target domain of the write: 0 main, 1 coprocessor |
| wr_sel | input | 2 | Source code to write |
| wr_pres | input | 3 | Prescaler code to write |
| irq_mask | input | 2 | Interrupt enable, one bit per domain |
| cfg_sel | output | 4 | Readback of the source codes, 2 bits per domain |
| cfg_pres | output | 6 | Readback of the prescaler codes, 3 bits per domain |
| ready | output | 2 | New master clock established, one bit per domain |
| irq | output | 2 | Ready interrupt request, one bit per domain |
| mck | output | 2 | Master clocks: bit 0 main domain, bit 1 coprocessor |

## Verification
The bench builds the block with its defaults: four sources, two domains, reset source 0 and two synchronizer stages. Half-periods of 100, 20, 5 and 8 ns are used, so every source has a distinct period. These source rates let the bench time each prescaler code exactly against a 10 ns source, including the 1-to-2 duty of the divide-by-3 ratio. Switching between the 200 ns slow clock and the 10 ns and 16 ns PLLs exercises handovers between widely different rates, in which a runt pulse or an early ready would be visible. Two back-to-back writes and mask changes on the second domain reach the restart path of the sequencer and both edges of the interrupt.

// File: rtl/mck_pkg.sv
package mck_pkg;

  // Prescaler code width; codes 0..6 are powers of two, the top code is divide-by-3
  localparam int PRES_W  = 3;
  localparam logic [PRES_W-1:0] PRES_DIV3 = '1;
  // Largest ratio is 2**(2**PRES_W-2); the counter must reach ratio-1
  localparam int CNT_W   = (1 << PRES_W) - 2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT_MUX,
    ST_WAIT_DIV
  } rdy_state_e;

  // Division ratio selected by a prescaler code
  function automatic int unsigned pres_ratio(input logic [PRES_W-1:0] code);
    if (code == PRES_DIV3) return 3;
    return 32'd1 << code;
  endfunction

  // Number of source cycles the divided output stays high
  function automatic int unsigned pres_high(input logic [PRES_W-1:0] code);
    if (code == PRES_DIV3) return 1;
    if (code == '0)        return 1;
    return (32'd1 << code) >> 1;
  endfunction

endpackage

// File: rtl/mck_glitchless_mux.sv
module mck_glitchless_mux #(
  parameter int NSRC      = 4,
  parameter int SEL_W     = 2,
  parameter int RESET_SRC = 0
) (
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_clk,
  input  logic [SEL_W-1:0] sel_app,
  output logic [NSRC-1:0]  src_en,
  output logic             mux_clk
);

  logic [NSRC-1:0] arm_vec;
  logic [NSRC-1:0] gated;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    localparam logic [NSRC-1:0] SELF    = NSRC'(1) << i;
    localparam logic            RST_VAL = (i == RESET_SRC);

    logic arm_q;
    logic en_q;
    logic want;

    // Start only when chosen and every other source is fully idle
    assign want = (sel_app == SEL_W'(i)) && ~|((src_en | arm_vec) & ~SELF);

    always_ff @(posedge src_clk[i] or negedge rst_n) begin
      if (!rst_n) arm_q <= RST_VAL;
      else        arm_q <= want;
    end

    // Enable moves only while this source is low
    always_ff @(negedge src_clk[i] or negedge rst_n) begin
      if (!rst_n) en_q <= RST_VAL;
      else        en_q <= arm_q;
    end

    assign arm_vec[i] = arm_q;
    assign src_en[i]  = en_q;
    assign gated[i]   = src_clk[i] & en_q;
  end

  assign mux_clk = |gated;

endmodule

// File: rtl/mck_prescaler.sv
module mck_prescaler
  import mck_pkg::*;
(
  input  logic              rst_n,
  input  logic              mux_clk,
  input  logic [PRES_W-1:0] pres_code,
  input  logic              req_tgl,
  output logic              ack_tgl,
  output logic              mck
);

  logic             req_m1, req_m2;
  logic             seen_q;
  logic             measuring_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_q;
  logic [CNT_W-1:0] high_q;
  logic             div_q;
  logic             byp_q;

  logic             boundary;
  logic             load_now;
  logic [CNT_W-1:0] cnt_nx;
  logic [CNT_W-1:0] new_last;
  logic [CNT_W-1:0] new_high;

  assign boundary = (cnt_q == last_q);
  assign load_now = boundary && (req_m2 != seen_q);
  assign cnt_nx   = cnt_q + 1'b1;
  assign new_last = CNT_W'(pres_ratio(pres_code) - 1);
  assign new_high = CNT_W'(pres_high(pres_code));

  always_ff @(posedge mux_clk or negedge rst_n) begin
    if (!rst_n) begin
      req_m1      <= 1'b0;
      req_m2      <= 1'b0;
      seen_q      <= 1'b0;
      measuring_q <= 1'b0;
      ack_tgl     <= 1'b0;
      cnt_q       <= '0;
      last_q      <= '0;
      high_q      <= CNT_W'(1);
      div_q       <= 1'b0;
    end else begin
      req_m1 <= req_tgl;
      req_m2 <= req_m1;
      if (boundary) begin
        cnt_q <= '0;
        if (measuring_q) begin
          ack_tgl     <= seen_q;
          measuring_q <= 1'b0;
        end
        if (load_now) begin
          seen_q      <= req_m2;
          last_q      <= new_last;
          high_q      <= new_high;
          measuring_q <= 1'b1;
          div_q       <= (new_last != '0);
        end else begin
          div_q <= (last_q != '0);
        end
      end else begin
        cnt_q <= cnt_nx;
        div_q <= (cnt_nx < high_q);
      end
    end
  end

  // Bypass choice changes only while the selected clock is low
  always_ff @(negedge mux_clk or negedge rst_n) begin
    if (!rst_n) byp_q <= 1'b1;
    else        byp_q <= (last_q == '0);
  end

  assign mck = (byp_q & mux_clk) | div_q;

endmodule

// File: rtl/mck_ready_ctrl.sv
module mck_ready_ctrl
  import mck_pkg::*;
#(
  parameter int NSRC        = 4,
  parameter int SEL_W       = 2,
  parameter int RESET_SRC   = 0,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [PRES_W-1:0] wr_pres,
  input  logic [NSRC-1:0]   src_en,
  input  logic              ack_tgl,
  output logic [SEL_W-1:0]  cfg_sel,
  output logic [PRES_W-1:0] cfg_pres,
  output logic [SEL_W-1:0]  sel_app,
  output logic              req_tgl,
  output logic              ready,
  output logic              mux_done
);

  localparam logic [NSRC-1:0] RESET_ONEHOT = NSRC'(1) << RESET_SRC;

  logic [NSRC-1:0]        en_pipe [SYNC_STAGES];
  logic [SYNC_STAGES-1:0] ack_pipe;
  logic                   ack_s;
  rdy_state_e             st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < SYNC_STAGES; k++) en_pipe[k] <= RESET_ONEHOT;
      ack_pipe <= '0;
    end else begin
      en_pipe[0] <= src_en;
      for (int k = 1; k < SYNC_STAGES; k++) en_pipe[k] <= en_pipe[k-1];
      ack_pipe <= {ack_pipe[SYNC_STAGES-2:0], ack_tgl};
    end
  end

  assign ack_s    = ack_pipe[SYNC_STAGES-1];
  assign mux_done = (en_pipe[SYNC_STAGES-1] == (NSRC'(1) << sel_app));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_sel  <= SEL_W'(RESET_SRC);
      cfg_pres <= '0;
      sel_app  <= SEL_W'(RESET_SRC);
      req_tgl  <= 1'b0;
      ready    <= 1'b1;
      st_q     <= ST_IDLE;
    end else if (wr) begin
      cfg_sel  <= wr_sel;
      cfg_pres <= wr_pres;
      ready    <= 1'b0;
      st_q     <= ST_WAIT_MUX;
    end else begin
      unique case (st_q)
        ST_WAIT_MUX: begin
          if (mux_done) begin
            if (sel_app != cfg_sel) begin
              sel_app <= cfg_sel;
            end else if (ack_s == req_tgl) begin
              req_tgl <= ~req_tgl;
              st_q    <= ST_WAIT_DIV;
            end
          end
        end
        ST_WAIT_DIV: begin
          if (ack_s == req_tgl) begin
            ready <= 1'b1;
            st_q  <= ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/mck_domain.sv
module mck_domain
  import mck_pkg::*;
#(
  parameter int NSRC        = 4,
  parameter int SEL_W       = 2,
  parameter int RESET_SRC   = 0,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_clk,
  input  logic              wr,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [PRES_W-1:0] wr_pres,
  input  logic              irq_mask,
  output logic [SEL_W-1:0]  cfg_sel,
  output logic [PRES_W-1:0] cfg_pres,
  output logic              ready,
  output logic              irq,
  output logic              mck,
  output logic [NSRC-1:0]   src_en,
  output logic [SEL_W-1:0]  sel_app,
  output logic              mux_done
);

  logic mux_clk;
  logic req_tgl;
  logic ack_tgl;

  mck_ready_ctrl #(
    .NSRC(NSRC), .SEL_W(SEL_W), .RESET_SRC(RESET_SRC), .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(wr), .wr_sel(wr_sel), .wr_pres(wr_pres),
    .src_en(src_en), .ack_tgl(ack_tgl), .cfg_sel(cfg_sel), .cfg_pres(cfg_pres),
    .sel_app(sel_app), .req_tgl(req_tgl), .ready(ready), .mux_done(mux_done)
  );

  mck_glitchless_mux #(
    .NSRC(NSRC), .SEL_W(SEL_W), .RESET_SRC(RESET_SRC)
  ) u_mux (
    .rst_n(rst_n), .src_clk(src_clk), .sel_app(sel_app),
    .src_en(src_en), .mux_clk(mux_clk)
  );

  mck_prescaler u_div (
    .rst_n(rst_n), .mux_clk(mux_clk), .pres_code(cfg_pres),
    .req_tgl(req_tgl), .ack_tgl(ack_tgl), .mck(mck)
  );

  assign irq = ready & irq_mask;

endmodule

// File: rtl/mck_sel_presc.sv
module mck_sel_presc
  import mck_pkg::*;
#(
  parameter int NSRC        = 4,
  parameter int NDOM        = 2,
  parameter int RESET_SRC   = 0,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = (NSRC > 1) ? $clog2(NSRC) : 1,
  localparam int DOM_W      = (NDOM > 1) ? $clog2(NDOM) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NSRC-1:0]          src_clk,
  input  logic                     wr_en,
  input  logic [DOM_W-1:0]         wr_dom,
  input  logic [SEL_W-1:0]         wr_sel,
  input  logic [PRES_W-1:0]        wr_pres,
  input  logic [NDOM-1:0]          irq_mask,
  output logic [NDOM*SEL_W-1:0]    cfg_sel,
  output logic [NDOM*PRES_W-1:0]   cfg_pres,
  output logic [NDOM-1:0]          ready,
  output logic [NDOM-1:0]          irq,
  output logic [NDOM-1:0]          mck
);

  // Internal events brought out for the checker
  logic [NDOM*NSRC-1:0]  src_en_w;
  logic [NDOM*SEL_W-1:0] sel_app_w;
  logic [NDOM-1:0]       mux_done_w;

  for (genvar d = 0; d < NDOM; d++) begin : g_dom
    logic wr_d;
    assign wr_d = wr_en && (wr_dom == DOM_W'(d));

    mck_domain #(
      .NSRC(NSRC), .SEL_W(SEL_W), .RESET_SRC(RESET_SRC), .SYNC_STAGES(SYNC_STAGES)
    ) u_dom (
      .clk(clk), .rst_n(rst_n), .src_clk(src_clk), .wr(wr_d),
      .wr_sel(wr_sel), .wr_pres(wr_pres), .irq_mask(irq_mask[d]),
      .cfg_sel(cfg_sel[d*SEL_W +: SEL_W]), .cfg_pres(cfg_pres[d*PRES_W +: PRES_W]),
      .ready(ready[d]), .irq(irq[d]), .mck(mck[d]),
      .src_en(src_en_w[d*NSRC +: NSRC]), .sel_app(sel_app_w[d*SEL_W +: SEL_W]),
      .mux_done(mux_done_w[d])
    );
  end

endmodule

// File: rtl/mck_sel_presc_chk.sv
module mck_sel_presc_chk
  import mck_pkg::*;
#(
  parameter int NSRC  = 4,
  parameter int NDOM  = 2,
  parameter int SEL_W = 2,
  parameter int DOM_W = 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wr_en,
  input logic [DOM_W-1:0]       wr_dom,
  input logic [SEL_W-1:0]       wr_sel,
  input logic [PRES_W-1:0]      wr_pres,
  input logic [NDOM*SEL_W-1:0]  cfg_sel,
  input logic [NDOM*PRES_W-1:0] cfg_pres,
  input logic [NDOM-1:0]        ready,
  input logic [NDOM-1:0]        irq,
  input logic [NDOM*NSRC-1:0]   src_en,
  input logic [NDOM*SEL_W-1:0]  sel_app,
  input logic [NDOM-1:0]        mux_done
);

  for (genvar d = 0; d < NDOM; d++) begin : g_chk
    assert_wr_clears_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_dom == DOM_W'(d)) |=> !ready[d]);

    assert_ready_after_handover_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready[d]) |-> mux_done[d]);

    assert_single_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(src_en[d*NSRC +: NSRC]));

    assert_select_moves_when_settled_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sel_app[d*SEL_W +: SEL_W]) |-> $past(mux_done[d]));

    assert_irq_drops_with_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ready[d]) |-> !irq[d]);

    assert_fields_written_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_dom == DOM_W'(d)) |=>
        (cfg_sel[d*SEL_W +: SEL_W] == $past(wr_sel)) &&
        (cfg_pres[d*PRES_W +: PRES_W] == $past(wr_pres)));
  end

endmodule

bind mck_sel_presc mck_sel_presc_chk #(
  .NSRC(NSRC), .NDOM(NDOM), .SEL_W(SEL_W), .DOM_W(DOM_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_dom(wr_dom), .wr_sel(wr_sel),
  .wr_pres(wr_pres), .cfg_sel(cfg_sel), .cfg_pres(cfg_pres), .ready(ready),
  .irq(irq), .src_en(src_en_w), .sel_app(sel_app_w), .mux_done(mux_done_w)
);

// File: tb/mck_sel_presc_tb.sv
`timescale 1ns/1ps
module mck_sel_presc_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       s0 = 1'b0, s1 = 1'b0, s2 = 1'b0, s3 = 1'b0;
  logic [3:0] src_clk;
  logic       wr_en = 1'b0;
  logic       wr_dom = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [2:0] wr_pres = '0;
  logic [1:0] irq_mask = '0;
  logic [3:0] cfg_sel;
  logic [5:0] cfg_pres;
  logic [1:0] ready, irq, mck;

  int checks = 0;
  int errors = 0;
  int glitches = 0;
  int cycles = 0;

  real src_per [4] = '{200.0, 40.0, 10.0, 16.0};

  assign src_clk = {s3, s2, s1, s0};

  always #5   clk = ~clk;
  always #100 s0 = ~s0;
  always #20  s1 = ~s1;
  always #5   s2 = ~s2;
  always #8   s3 = ~s3;

  mck_sel_presc u_dut (
    .clk(clk), .rst_n(rst_n), .src_clk(src_clk), .wr_en(wr_en), .wr_dom(wr_dom),
    .wr_sel(wr_sel), .wr_pres(wr_pres), .irq_mask(irq_mask), .cfg_sel(cfg_sel),
    .cfg_pres(cfg_pres), .ready(ready), .irq(irq), .mck(mck)
  );

  // Runt-pulse monitor: no phase shorter than the 5 ns fastest half period (R8)
  real last0 = 0.0, last1 = 0.0;
  bit  seen0 = 0, seen1 = 0;
  always @(posedge mck[0] or negedge mck[0]) begin
    if (seen0 && ($realtime - last0) < 4.99) glitches++;
    seen0 = 1; last0 = $realtime;
  end
  always @(posedge mck[1] or negedge mck[1]) begin
    if (seen1 && ($realtime - last1) < 4.99) glitches++;
    seen1 = 1; last1 = $realtime;
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected under 150000", cycles);
      summary();
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input real act, input real exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0.2f expected %0.2f", tag, what, act, exp);
    end
  endtask

  function automatic int exp_ratio(input int code);
    return (code == 7) ? 3 : (1 << code);
  endfunction

  function automatic real exp_high(input int sel, input int code);
    if (code == 0) return src_per[sel] / 2.0;
    if (code == 7) return src_per[sel];
    return src_per[sel] * exp_ratio(code) / 2.0;
  endfunction

  task automatic wait_edge(input int d, input bit rising);
    if (d == 0) begin
      if (rising) @(posedge mck[0]); else @(negedge mck[0]);
    end else begin
      if (rising) @(posedge mck[1]); else @(negedge mck[1]);
    end
  endtask

  task automatic measure(input int d, output real per, output real hi);
    real t0, t1, t2;
    wait_edge(d, 1);
    wait_edge(d, 1);
    t0 = $realtime;
    wait_edge(d, 0);
    t1 = $realtime;
    wait_edge(d, 1);
    t2 = $realtime;
    per = t2 - t0;
    hi  = t1 - t0;
  endtask

  // Write one domain; checks R3, R10 and R11 one cycle later
  task automatic write_cfg(input int d, input int sel, input int pres);
    logic other_ready;
    @(negedge clk);
    other_ready = ready[1-d];
    wr_en = 1'b1; wr_dom = d[0]; wr_sel = sel[1:0]; wr_pres = pres[2:0];
    @(negedge clk);
    wr_en = 1'b0;
    check(ready[d] == 1'b0, "R3", "ready after write", real'(ready[d]), 0.0);
    check(ready[1-d] == other_ready, "R10", "other domain ready",
          real'(ready[1-d]), real'(other_ready));
    check(cfg_sel[d*2 +: 2] == sel[1:0], "R11", "source readback",
          real'(cfg_sel[d*2 +: 2]), real'(sel));
    check(cfg_pres[d*3 +: 3] == pres[2:0], "R11", "prescaler readback",
          real'(cfg_pres[d*3 +: 3]), real'(pres));
  endtask

  task automatic wait_ready(input int d, output int waited);
    waited = 0;
    while (ready[d] == 1'b0 && waited < 20000) begin
      @(negedge clk);
      waited++;
    end
    check(ready[d] == 1'b1, "R4", "ready returns", real'(ready[d]), 1.0);
  endtask

  // Switch, wait for ready and time the master clock
  task automatic switch_and_time(input int d, input int sel, input int pres, input string tag);
    int  waited;
    real per, hi, eper;
    eper = src_per[sel] * exp_ratio(pres);
    write_cfg(d, sel, pres);
    wait_ready(d, waited);
    check(waited * 10.0 + 10.0 >= eper, "R4", "ready low time covers one new period",
          waited * 10.0, eper);
    measure(d, per, hi);
    check(per > eper - 0.01 && per < eper + 0.01, tag, "period", per, eper);
    check(hi > exp_high(sel, pres) - 0.01 && hi < exp_high(sel, pres) + 0.01,
          tag, "high phase", hi, exp_high(sel, pres));
  endtask

  task automatic t_reset();
    real per, hi;
    check(ready == 2'b11, "R1", "ready after reset", real'(ready), 3.0);
    check(irq == 2'b00, "R1", "irq after reset", real'(irq), 0.0);
    check(cfg_sel == 4'd0 && cfg_pres == 6'd0, "R1", "fields after reset",
          real'({cfg_sel, cfg_pres}), 0.0);
    for (int d = 0; d < 2; d++) begin
      measure(d, per, hi);
      check(per > 199.99 && per < 200.01, "R1", "reset period", per, 200.0);
    end
  endtask

  task automatic t_sources();
    real per, hi;
    switch_and_time(0, 1, 0, "R2");
    switch_and_time(0, 2, 0, "R2");
    switch_and_time(0, 3, 0, "R2");
    measure(1, per, hi);
    check(per > 199.99 && per < 200.01, "R10", "other domain period", per, 200.0);
    switch_and_time(0, 0, 0, "R2");
  endtask

  task automatic t_pow2();
    for (int p = 1; p < 7; p++) switch_and_time(0, 2, p, "R5");
    switch_and_time(0, 3, 3, "R7");
  endtask

  task automatic t_div3();
    switch_and_time(1, 3, 7, "R6");
    switch_and_time(0, 1, 7, "R6");
    switch_and_time(1, 2, 7, "R6");
  endtask

  task automatic t_back_to_back();
    int  waited;
    real per, hi;
    write_cfg(0, 1, 0);
    write_cfg(0, 3, 2);
    wait_ready(0, waited);
    measure(0, per, hi);
    check(per > 63.99 && per < 64.01, "R11", "second write wins", per, 64.0);
  endtask

  task automatic t_irq();
    int waited;
    @(negedge clk);
    check(irq[1] == 1'b0, "R9", "irq masked", real'(irq[1]), 0.0);
    irq_mask = 2'b10;
    @(negedge clk);
    check(irq == 2'b10, "R9", "irq with mask set", real'(irq), 2.0);
    write_cfg(1, 1, 1);
    check(irq[1] == 1'b0, "R9", "irq drops on write", real'(irq[1]), 0.0);
    wait_ready(1, waited);
    @(negedge clk);
    check(irq[1] == 1'b1, "R9", "irq after ready", real'(irq[1]), 1.0);
    irq_mask = 2'b00;
    @(negedge clk);
    check(irq[1] == 1'b0, "R9", "irq after mask clear", real'(irq[1]), 0.0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_sources();
    t_pow2();
    t_div3();
    t_back_to_back();
    t_irq();
    check(glitches == 0, "R8", "runt pulses on master clocks", real'(glitches), 0.0);
    summary();
    $finish;
  end

endmodule